// File: doc/BRIEF.md
# Engine Channel Run Controller

This block holds the run state of a small set of independent copy/XOR engine channels and reports their progress to software through one interrupt line. For each channel, software writes one command word into that channel's activation register. The word can request start, stop, pause or restart. The register reads back the channel's present run state as a two-bit code.

A datapath outside the block reports events as single-cycle pulses:

- end of descriptor and end of chain;
- three kinds of bus error.

These events, together with the stop and pause transitions, set flags in a shared cause register. Each channel has its own 16-bit lane in that register. A mask register with the same layout selects which flags drive the interrupt output. The interrupt output is registered.

Software reaches the registers through a single-cycle word port.

- Write: `reg_wr` is high for one clock.
- Read: `reg_rdata` follows `reg_addr` combinationally.
- Address map: activation registers sit at word addresses 0 to NUM_CH-1, the cause register at NUM_CH, and the mask register at NUM_CH+1.

Top module: `xeng_run_ctrl`

## Requirements
- R1: After reset every channel is in the not-active state, and the cause register, the mask register and `irq` are all zero.
- R2: A write of bit 0 (start) to a channel's activation register moves a not-active channel to active. In any other state start has no effect.
- R3: Bit 2 (pause) moves an active channel to paused and sets lane bit 3 (paused flag). In any other state pause has no effect.
- R4: Bit 3 (restart) moves a paused channel back to active. In any other state restart has no effect.
- R5: Bit 1 (stop) moves an active or paused channel to not active and sets lane bit 2 (stopped flag). A stop written to a not-active channel has no effect.
- R6: When several command bits are written together, only the highest-priority one is considered: stop first, then pause, then start and restart. If that command is not legal in the present state, nothing happens.
- R7: An activation register reads the run state in bits [5:4], encoded as 0 = not active, 1 = active, 2 = paused. Bits [3:0] read as zero, and the result of a write is readable on the next cycle.
- R8: While a channel is active, an end-of-descriptor pulse sets lane bit 0. An end-of-chain pulse sets lane bit 1 and moves the channel to not active. Both pulses are ignored while the channel is not active.
- R9: Error pulses set lane bit 5 (access violation), bit 6 (write protect) or bit 7 (ownership) in any run state.
- R10: Channel c's flags sit at bit offset 16*c of the cause and mask registers. The channels change state independently of each other.
- R11: Writing the cause register clears each flag whose data bit is 0 and leaves flags with data bit 1 unchanged. A flag set by hardware in the same cycle as a software clear stays set.
- R12: `irq` is the OR of (cause AND mask), registered, so it follows the cause and mask registers one cycle later.
- R13: Lane bits 4 and 8 to 15 are not implemented in the cause or mask register and always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| ev_eod | input | NUM_CH | End-of-descriptor pulse per channel |
| ev_eoc | input | NUM_CH | End-of-chain pulse per channel |
| ev_acc_err | input | NUM_CH | Access violation pulse per channel |
| ev_wp_err | input | NUM_CH | Write-protect violation pulse per channel |
| ev_own_err | input | NUM_CH | Ownership violation pulse per channel |
| ch_status | output | 2*NUM_CH | Run state per channel, two bits each |
| irq | output | 1 | Masked interrupt request, registered |

## Verification
Commands, events and cause writes are all captured on one rising edge. The run state and the cause flags they produce are visible from that edge on. The bench therefore drives inputs on a falling edge and checks status and read-back at the next falling edge. `irq` passes through one more register. Its checks sample one falling edge later than the cause change that drives them, and they also confirm the old value is still present at the first falling edge. Same-cycle cases are driven in a single cycle: a clear together with a hardware set, and several command bits in one word.

// File: rtl/xeng_pkg.sv
package xeng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_state_e;

    // activation command bit positions
    localparam int CMD_GO     = 0;
    localparam int CMD_KILL   = 1;
    localparam int CMD_HOLD   = 2;
    localparam int CMD_RESUME = 3;
    localparam int CMD_W      = 4;

    // status field position in the activation word
    localparam int STAT_LSB = 4;

    // per-lane flag positions
    localparam int LB_EOD   = 0;
    localparam int LB_EOC   = 1;
    localparam int LB_STOP  = 2;
    localparam int LB_PAUSE = 3;
    localparam int LB_ACC   = 5;
    localparam int LB_WP    = 6;
    localparam int LB_OWN   = 7;

endpackage

// File: rtl/xeng_chan_fsm.sv
module xeng_chan_fsm
    import xeng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              ev_eod,
    input  logic              ev_eoc,
    output run_state_e        state_o,
    output logic              set_eod,
    output logic              set_eoc,
    output logic              set_stop,
    output logic              set_pause
);

    typedef struct packed {
        run_state_e st;
    } chan_q_t;

    chan_q_t cur_q, nxt_d;

    logic kill_d, hold_d, go_d, resume_d;

    always_comb begin
        // priority resolution: stop, then pause, then start/restart
        kill_d   = cmd_wr & cmd[CMD_KILL];
        hold_d   = cmd_wr & cmd[CMD_HOLD] & ~cmd[CMD_KILL];
        go_d     = cmd_wr & cmd[CMD_GO] & ~cmd[CMD_KILL] & ~cmd[CMD_HOLD];
        resume_d = cmd_wr & cmd[CMD_RESUME] & ~cmd[CMD_KILL] & ~cmd[CMD_HOLD];

        nxt_d     = cur_q;
        set_stop  = 1'b0;
        set_pause = 1'b0;
        set_eod   = ev_eod & (cur_q.st == ST_RUN);
        set_eoc   = ev_eoc & (cur_q.st == ST_RUN);

        unique case (cur_q.st)
            ST_IDLE: begin
                if (go_d) nxt_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (kill_d) begin
                    nxt_d.st = ST_IDLE;
                    set_stop = 1'b1;
                end else if (hold_d) begin
                    nxt_d.st  = ST_HALT;
                    set_pause = 1'b1;
                end else if (ev_eoc) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (kill_d) begin
                    nxt_d.st = ST_IDLE;
                    set_stop = 1'b1;
                end else if (resume_d) begin
                    nxt_d.st = ST_RUN;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE};
        else        cur_q <= nxt_d;
    end

    assign state_o = cur_q.st;

    assert_legal_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.st != 2'd3);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd[CMD_GO] && !cmd[CMD_KILL] && !cmd[CMD_HOLD] && cur_q.st == ST_IDLE)
        |=> (cur_q.st == ST_RUN));

    assert_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd[CMD_HOLD] && !cmd[CMD_KILL] && cur_q.st == ST_RUN)
        |=> (cur_q.st == ST_HALT));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd[CMD_RESUME] && !cmd[CMD_KILL] && !cmd[CMD_HOLD] && cur_q.st == ST_HALT)
        |=> (cur_q.st == ST_RUN));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd[CMD_KILL]) |=> (cur_q.st == ST_IDLE));

    assert_chain_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_eoc && cur_q.st == ST_RUN && !(cmd_wr && (cmd[CMD_KILL] || cmd[CMD_HOLD])))
        |=> (cur_q.st == ST_IDLE));

    assert_no_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !ev_eoc) |=> $stable(cur_q.st));

endmodule

// File: rtl/xeng_cause_bank.sv
module xeng_cause_bank #(
    parameter int          NUM_CH    = 2,
    parameter int          LANE_W    = 16,
    parameter logic [15:0] LANE_IMPL = 16'h00EF,
    localparam int         CAUSE_W   = NUM_CH * LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cause_wr,
    input  logic               mask_wr,
    input  logic [CAUSE_W-1:0] wdata,
    input  logic [CAUSE_W-1:0] hw_set,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] mask_o,
    output logic               irq_o
);

    logic [CAUSE_W-1:0] impl_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_impl
        assign impl_vec[c*LANE_W +: LANE_W] = LANE_W'(LANE_IMPL);
    end

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic [CAUSE_W-1:0] mask;
        logic               irq;
    } bank_q_t;

    bank_q_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cause_wr) nxt_d.cause = cur_q.cause & wdata;
        nxt_d.cause = (nxt_d.cause | hw_set) & impl_vec;
        if (mask_wr) nxt_d.mask = wdata & impl_vec;
        nxt_d.irq = |(cur_q.cause & cur_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cause_o = cur_q.cause;
    assign mask_o  = cur_q.mask;
    assign irq_o   = cur_q.irq;

    assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & impl_vec)) |=> ((cur_q.cause & $past(hw_set & impl_vec)) == $past(hw_set & impl_vec)));

    assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(cur_q.cause & cur_q.mask)) |=> !cur_q.irq);

    assert_irq_raise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(cur_q.cause & cur_q.mask)) |=> cur_q.irq);

    assert_unimpl_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.cause | cur_q.mask) & ~impl_vec) == '0);

    assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cause_wr) |=> ((cur_q.cause & $past(cur_q.cause)) == $past(cur_q.cause)));

endmodule

// File: rtl/xeng_run_ctrl.sv
module xeng_run_ctrl
    import xeng_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int LANE_W = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_CH-1:0]   ev_eod,
    input  logic [NUM_CH-1:0]   ev_eoc,
    input  logic [NUM_CH-1:0]   ev_acc_err,
    input  logic [NUM_CH-1:0]   ev_wp_err,
    input  logic [NUM_CH-1:0]   ev_own_err,
    output logic [2*NUM_CH-1:0] ch_status,
    output logic                irq
);

    localparam int              CAUSE_W    = NUM_CH * LANE_W;
    localparam int              CH_IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] CAUSE_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(NUM_CH + 1);

    run_state_e         st_arr [NUM_CH];
    logic [CAUSE_W-1:0] hw_set;
    logic [CAUSE_W-1:0] cause_q, mask_q;
    logic               cause_wr, mask_wr;

    assign cause_wr = reg_wr & (reg_addr == CAUSE_ADDR);
    assign mask_wr  = reg_wr & (reg_addr == MASK_ADDR);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic cmd_wr;
        logic s_eod, s_eoc, s_stop, s_pause;

        assign cmd_wr = reg_wr & (reg_addr == ADDR_W'(c));

        xeng_chan_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_wr    (cmd_wr),
            .cmd       (reg_wdata[CMD_W-1:0]),
            .ev_eod    (ev_eod[c]),
            .ev_eoc    (ev_eoc[c]),
            .state_o   (st_arr[c]),
            .set_eod   (s_eod),
            .set_eoc   (s_eoc),
            .set_stop  (s_stop),
            .set_pause (s_pause)
        );

        always_comb begin
            hw_set[c*LANE_W +: LANE_W]           = '0;
            hw_set[c*LANE_W + LB_EOD]   = s_eod;
            hw_set[c*LANE_W + LB_EOC]   = s_eoc;
            hw_set[c*LANE_W + LB_STOP]  = s_stop;
            hw_set[c*LANE_W + LB_PAUSE] = s_pause;
            hw_set[c*LANE_W + LB_ACC]   = ev_acc_err[c];
            hw_set[c*LANE_W + LB_WP]    = ev_wp_err[c];
            hw_set[c*LANE_W + LB_OWN]   = ev_own_err[c];
        end

        assign ch_status[2*c +: 2] = st_arr[c];
    end

    xeng_cause_bank #(
        .NUM_CH (NUM_CH),
        .LANE_W (LANE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cause_wr (cause_wr),
        .mask_wr  (mask_wr),
        .wdata    (reg_wdata[CAUSE_W-1:0]),
        .hw_set   (hw_set),
        .cause_o  (cause_q),
        .mask_o   (mask_q),
        .irq_o    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < CAUSE_ADDR) begin
            reg_rdata[STAT_LSB +: 2] = st_arr[reg_addr[CH_IDX_W-1:0]];
        end else if (reg_addr == CAUSE_ADDR) begin
            reg_rdata[CAUSE_W-1:0] = cause_q;
        end else if (reg_addr == MASK_ADDR) begin
            reg_rdata[CAUSE_W-1:0] = mask_q;
        end
    end

    assert_cmd_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < CAUSE_ADDR) |-> (reg_rdata[CMD_W-1:0] == '0));

    assert_stop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[CMD_KILL] && ch_status[1:0] != 2'd0)
        |=> cause_q[LB_STOP]);

endmodule

// File: tb/xeng_run_ctrl_bench.sv
module xeng_run_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 17;

    // {command[3:0], expected status[1:0], expected cause lane0 low nibble[3:0]}
    localparam logic [9:0] VEC [NV] = '{
        {4'h1, 2'd1, 4'h0},  // R2 start from idle
        {4'h1, 2'd1, 4'h0},  // R2 start ignored while active
        {4'h8, 2'd1, 4'h0},  // R4 restart ignored while active
        {4'h4, 2'd2, 4'h8},  // R3 pause from active
        {4'h4, 2'd2, 4'h8},  // R3 pause ignored while paused
        {4'h1, 2'd2, 4'h8},  // R2 start ignored while paused
        {4'h8, 2'd1, 4'h8},  // R4 restart from paused
        {4'h2, 2'd0, 4'hC},  // R5 stop from active
        {4'h2, 2'd0, 4'hC},  // R5 stop ignored while idle
        {4'h4, 2'd0, 4'hC},  // R3 pause ignored while idle
        {4'h3, 2'd0, 4'hC},  // R6 stop+start: stop considered, no effect
        {4'h1, 2'd1, 4'hC},  // R2
        {4'hD, 2'd2, 4'hC},  // R6 pause beats start/restart
        {4'h6, 2'd0, 4'hC},  // R6 stop beats pause, from paused
        {4'h8, 2'd0, 4'hC},  // R4 restart ignored while idle
        {4'h9, 2'd1, 4'hC},  // R6 start+restart from idle
        {4'h2, 2'd0, 4'hC}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ev_eod = '0, ev_eoc = '0, ev_acc_err = '0, ev_wp_err = '0, ev_own_err = '0;
    logic [3:0]  ch_status;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xeng_run_ctrl u_xeng_run_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ev_eod     (ev_eod),
        .ev_eoc     (ev_eoc),
        .ev_acc_err (ev_acc_err),
        .ev_wp_err  (ev_wp_err),
        .ev_own_err (ev_own_err),
        .ch_status  (ch_status),
        .irq        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // event codes: 0 eod, 1 eoc, 2 acc, 3 wp, 4 own
    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        case (kind)
            0: ev_eod[ch] = 1'b1;
            1: ev_eoc[ch] = 1'b1;
            2: ev_acc_err[ch] = 1'b1;
            3: ev_wp_err[ch] = 1'b1;
            default: ev_own_err[ch] = 1'b1;
        endcase
        @(negedge clk);
        ev_eod = '0; ev_eoc = '0; ev_acc_err = '0; ev_wp_err = '0; ev_own_err = '0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {28'd0, ch_status}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd_chk("R1 cause", 4'd2, 32'd0);
        rd_chk("R1 mask", 4'd3, 32'd0);

        // vector walk on channel 0
        for (int i = 0; i < NV; i++) begin
            wr(4'd0, {28'd0, VEC[i][9:6]});
            rd_chk("R7 act0 readback", 4'd0, {26'd0, VEC[i][5:4], 4'd0});
            rd_chk("R3/R5 cause lane0", 4'd2, {28'd0, VEC[i][3:0]});
            chk("R10 ch1 untouched", {30'd0, ch_status[3:2]}, 32'd0);
        end

        // R11 write-zero clears
        wr(4'd2, 32'hFFFF_FFFB);
        rd_chk("R11 partial clear", 4'd2, 32'h0000_0008);
        wr(4'd2, 32'd0);
        rd_chk("R11 full clear", 4'd2, 32'd0);

        // R13 unimplemented bits
        wr(4'd3, 32'hFFFF_FFFF);
        rd_chk("R13 mask readback", 4'd3, 32'h00EF_00EF);
        wr(4'd3, 32'd0);

        // R8 / R10 on channel 1
        wr(4'd1, 32'd1);
        chk("R10 ch1 active", {30'd0, ch_status[3:2]}, 32'd1);
        chk("R10 ch0 idle", {30'd0, ch_status[1:0]}, 32'd0);
        pulse(0, 1);
        rd_chk("R8 eod flag", 4'd2, 32'h0001_0000);
        chk("R8 still active", {30'd0, ch_status[3:2]}, 32'd1);
        pulse(1, 1);
        rd_chk("R8 eoc flag", 4'd2, 32'h0003_0000);
        chk("R8 eoc to idle", {30'd0, ch_status[3:2]}, 32'd0);
        wr(4'd2, 32'd0);
        pulse(0, 1);
        pulse(1, 1);
        rd_chk("R8 ignored idle", 4'd2, 32'd0);
        chk("R8 idle stays", {30'd0, ch_status[3:2]}, 32'd0);

        // R9 errors in idle state
        pulse(2, 1);
        rd_chk("R9 acc", 4'd2, 32'h0020_0000);
        pulse(3, 1);
        rd_chk("R9 wp", 4'd2, 32'h0060_0000);
        pulse(4, 1);
        rd_chk("R9 own", 4'd2, 32'h00E0_0000);
        wr(4'd2, 32'd0);

        // R11 hardware set wins over same-cycle clear
        pulse(3, 0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = 32'd0; ev_own_err[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_own_err = '0;
        rd_chk("R11 set beats clear", 4'd2, 32'h0000_0080);

        // R12 irq timing
        chk("R12 masked off", {31'd0, irq}, 32'd0);
        wr(4'd3, 32'h0000_0080);
        chk("R12 not yet", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R12 raised", {31'd0, irq}, 32'd1);
        wr(4'd2, 32'd0);
        chk("R12 held one cycle", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R12 dropped", {31'd0, irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule